// File: doc/BRIEF.md
# Multichannel Range Flag Alarm Latch

This block keeps per-channel status for a sixteen-channel data acquisition front end. Each channel delivers a converted signed sample with a valid strobe, together with its own low and high process limits. On every strobe the channel registers three results. The first is a clamped data value: a sample above the normal operating range reports the top of that range, and a sample below it reports the bottom. The second is a pair of over-range and under-range flags that follow the current sample and clear by themselves. The third is a pair of low and high process alarms that latch.

An alarm latches only when its condition appears, meaning it was absent on the previous sample and is present now. It also latches only while that channel's cancel bit is clear. Once set, the alarm stays set after the condition goes away. A host clears it by holding the matching cancel bit. The alarm then drops on the first sample where its condition is absent. While the condition persists, the cancel bit does nothing.

The host writes cancel bits as a flat vector of control words and reads status as a flat vector of status words. Each status word packs four channels.

Top module: `range_alarm_monitor`

## Requirements
- R1: After a synchronous reset every data output is 0 and every status bit (range flags and latched alarms) is 0.
- R2: On a strobe with a sample above RANGE_MAX, the channel's over-range flag becomes 1 and its data output becomes RANGE_MAX. The flag returns to 0 on the next strobe whose sample is within range.
- R3: On a strobe with a sample below RANGE_MIN, the channel's under-range flag becomes 1 and its data output becomes RANGE_MIN. The flag returns to 0 on the next strobe whose sample is within range.
- R4: On a strobe with RANGE_MIN <= sample <= RANGE_MAX, the data output equals the sample and both range flags are 0.
- R5: The high alarm condition is sample >= high limit, compared as signed values. The high alarm latches on a strobe where the condition is present, it was absent on the previous strobe (or no strobe has occurred since reset), and the channel's high cancel bit is 0. The latched alarm stays 1 after the condition ends while cancel is 0.
- R6: The low alarm condition is sample <= low limit, compared as signed values. The low alarm follows the same latching rule as the high alarm, using the low cancel bit.
- R7: A latched alarm clears on the first strobe where its cancel bit is 1 and its condition is absent. A strobe where the condition is still present leaves the alarm at 1 whatever the cancel bit is.
- R8: An appearance of the alarm condition on a strobe while the cancel bit is 1 does not latch. Later strobes on which the condition merely persists do not latch it either, even after cancel returns to 0.
- R9: Bit layout. Cancel vector bit 2n is channel n's high cancel and bit 2n+1 is its low cancel, which places channels 0-7 in the first 16-bit word and 8-15 in the second. In status vector nibble n (bits 4n..4n+3), bit 0 is over-range, bit 1 under-range, bit 2 latched low alarm and bit 3 latched high alarm. Status word k therefore holds channels 4k to 4k+3.
- R10: A channel's data, flags and alarm state change only on a clock where its sample_valid bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | NCH | Per-channel new-sample strobe |
| sample_in | input | NCH*DW | Signed samples, channel n at bits n*DW +: DW |
| lo_limit_in | input | NCH*DW | Signed low alarm limits, same layout |
| hi_limit_in | input | NCH*DW | Signed high alarm limits, same layout |
| cancel_words | input | 2*NCH | Cancel bits, two per channel (R9) |
| data_out | output | NCH*DW | Clamped data, channel n at bits n*DW +: DW |
| status_words | output | 4*NCH | Packed status, one nibble per channel (R9) |

## Verification
The bench builds the block with the default 16 channels and 16-bit data, but narrows RANGE_MIN and RANGE_MAX to -1000 and 1000. With that range, uniformly drawn samples between -1500 and 1500 regularly cross both range edges. The per-channel alarm limits are spread inside the range, so alarm appearance, persistence and disappearance all occur often. The random cancel bits and the partial strobe masks then combine cancel-while-persisting, cancel-at-appearance and skipped-strobe cases across all sixteen nibbles. Directed sequences on single channels pin down the exact clearing sample and the ignored appearance.

// File: rtl/range_alarm_pkg.sv
package range_alarm_pkg;
  localparam int STAT_BITS = 4;
  localparam int CANCEL_BITS = 2;

  // One status nibble: bit0 over, bit1 under, bit2 low alarm, bit3 high alarm
  typedef struct packed {
    logic hi_alm;
    logic lo_alm;
    logic under;
    logic over;
  } ch_stat_t;
endpackage

// File: rtl/range_clamp.sv
module range_clamp #(
  parameter int DW = 16,
  parameter logic signed [DW-1:0] RMIN = -16'sd16384,
  parameter logic signed [DW-1:0] RMAX = 16'sd16383
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic signed [DW-1:0] sample,
  output logic signed [DW-1:0] data_q,
  output logic                 over_q,
  output logic                 under_q
);
  function automatic logic signed [DW-1:0] clamp_fn(input logic signed [DW-1:0] v);
    if (v > RMAX) return RMAX;
    if (v < RMIN) return RMIN;
    return v;
  endfunction

  logic is_over, is_under;
  assign is_over  = (sample > RMAX);
  assign is_under = (sample < RMIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else if (valid) begin
      data_q  <= clamp_fn(sample);
      over_q  <= is_over;
      under_q <= is_under;
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(over_q && under_q)); // R2
  AST_CLAMP_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    over_q |-> (data_q == RMAX)); // R2
  AST_CLAMP_AT_MIN: assert property (@(posedge clk) disable iff (rst)
    under_q |-> (data_q == RMIN)); // R3
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(data_q)); // R10
endmodule

// File: rtl/alarm_bit.sv
module alarm_bit (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic cond,
  input  logic cancel,
  output logic alm
);
  logic prev_cond;
  logic appear_ev, set_ev, clear_ev;

  assign appear_ev = valid & cond & ~prev_cond;
  assign set_ev    = appear_ev & ~alm & ~cancel;
  assign clear_ev  = valid & alm & cancel & ~cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm       <= 1'b0;
      prev_cond <= 1'b0;
    end else if (valid) begin
      prev_cond <= cond;
      if (set_ev)        alm <= 1'b1;
      else if (clear_ev) alm <= 1'b0;
    end
  end

  AST_STICKY_WITHOUT_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (valid && alm && !cancel) |=> alm); // R5
  AST_PERSIST_BLOCKS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (valid && alm && cond) |=> alm); // R7
  AST_CANCEL_BLOCKS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (valid && !alm && cancel) |=> !alm); // R8
  AST_ALARM_STEADY: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(alm)); // R10
endmodule

// File: rtl/range_alarm_monitor.sv
module range_alarm_monitor
  import range_alarm_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 16,
  parameter logic signed [DW-1:0] RANGE_MIN = -16'sd16384,
  parameter logic signed [DW-1:0] RANGE_MAX = 16'sd16383
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       sample_valid,
  input  logic [NCH*DW-1:0]    sample_in,
  input  logic [NCH*DW-1:0]    lo_limit_in,
  input  logic [NCH*DW-1:0]    hi_limit_in,
  input  logic [CANCEL_BITS*NCH-1:0] cancel_words,
  output logic [NCH*DW-1:0]    data_out,
  output logic [STAT_BITS*NCH-1:0]   status_words
);
  function automatic logic at_or_above(input logic signed [DW-1:0] v,
                                       input logic signed [DW-1:0] lim);
    return v >= lim;
  endfunction

  function automatic logic at_or_below(input logic signed [DW-1:0] v,
                                       input logic signed [DW-1:0] lim);
    return v <= lim;
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic signed [DW-1:0] smp, lo_lim, hi_lim, dq;
    logic hi_cond, lo_cond, cancel_hi, cancel_lo;
    ch_stat_t st;

    assign smp       = sample_in[g*DW +: DW];
    assign lo_lim    = lo_limit_in[g*DW +: DW];
    assign hi_lim    = hi_limit_in[g*DW +: DW];
    assign cancel_hi = cancel_words[CANCEL_BITS*g];
    assign cancel_lo = cancel_words[CANCEL_BITS*g + 1];
    assign hi_cond   = at_or_above(smp, hi_lim);
    assign lo_cond   = at_or_below(smp, lo_lim);

    range_clamp #(.DW(DW), .RMIN(RANGE_MIN), .RMAX(RANGE_MAX)) u_clamp (
      .clk(clk), .rst(rst), .valid(sample_valid[g]), .sample(smp),
      .data_q(dq), .over_q(st.over), .under_q(st.under)
    );

    alarm_bit u_hi (
      .clk(clk), .rst(rst), .valid(sample_valid[g]), .cond(hi_cond),
      .cancel(cancel_hi), .alm(st.hi_alm)
    );

    alarm_bit u_lo (
      .clk(clk), .rst(rst), .valid(sample_valid[g]), .cond(lo_cond),
      .cancel(cancel_lo), .alm(st.lo_alm)
    );

    assign data_out[g*DW +: DW]               = dq;
    assign status_words[g*STAT_BITS +: STAT_BITS] = st;

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (st == '0 && dq == '0)); // R1
  end
endmodule

// File: tb/tb_range_alarm_monitor.sv
`timescale 1ns/1ps
module tb_range_alarm_monitor;
  localparam int NCH = 16;
  localparam int DW  = 16;
  localparam int RMIN = -1000;
  localparam int RMAX = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]    sample_valid = '0;
  logic [NCH*DW-1:0] sample_in = '0;
  logic [NCH*DW-1:0] lo_limit_in = '0;
  logic [NCH*DW-1:0] hi_limit_in = '0;
  logic [2*NCH-1:0]  cancel_words = '0;
  logic [NCH*DW-1:0] data_out;
  logic [4*NCH-1:0]  status_words;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_data[NCH];
  bit m_ov[NCH], m_un[NCH], m_hi[NCH], m_lo[NCH], m_ph[NCH], m_pl[NCH];
  int lim_hi[NCH], lim_lo[NCH];

  always #2.5 clk = ~clk;

  range_alarm_monitor #(.NCH(NCH), .DW(DW),
    .RANGE_MIN(16'(RMIN)), .RANGE_MAX(16'(RMAX))) dut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
    .lo_limit_in(lo_limit_in), .hi_limit_in(hi_limit_in),
    .cancel_words(cancel_words), .data_out(data_out), .status_words(status_words)
  );

  function automatic int smp_of(int ch);
    logic signed [DW-1:0] s;
    s = sample_in[ch*DW +: DW];
    return int'(s);
  endfunction

  // Latch rule restated: a held alarm survives unless cancel meets an absent
  // condition; a free alarm starts only on a fresh appearance with cancel low.
  function automatic bit next_alarm(bit cur, bit cond, bit prev, bit cancel);
    if (cur) return cond || !cancel;
    return cond && !prev && !cancel;
  endfunction

  task automatic model_step();
    for (int ch = 0; ch < NCH; ch++) begin
      if (sample_valid[ch]) begin
        int v;
        bit hc, lc;
        v = smp_of(ch);
        m_ov[ch] = v > RMAX;
        m_un[ch] = v < RMIN;
        m_data[ch] = m_ov[ch] ? RMAX : (m_un[ch] ? RMIN : v);
        hc = v >= lim_hi[ch];
        lc = v <= lim_lo[ch];
        m_hi[ch] = next_alarm(m_hi[ch], hc, m_ph[ch], cancel_words[2*ch]);
        m_lo[ch] = next_alarm(m_lo[ch], lc, m_pl[ch], cancel_words[2*ch+1]);
        m_ph[ch] = hc;
        m_pl[ch] = lc;
      end
    end
  endtask

  task automatic check_all(string tag);
    for (int ch = 0; ch < NCH; ch++) begin
      logic [DW-1:0] exp_d;
      logic [3:0] exp_s;
      exp_d = m_data[ch][DW-1:0];
      exp_s = {m_hi[ch], m_lo[ch], m_un[ch], m_ov[ch]};
      checks++;
      if (data_out[ch*DW +: DW] !== exp_d) begin
        failures++;
        $display("FAIL %s ch%0d data actual=%0h expected=%0h", tag, ch,
                 data_out[ch*DW +: DW], exp_d);
      end
      checks++;
      if (status_words[4*ch +: 4] !== exp_s) begin
        failures++;
        $display("FAIL %s ch%0d status actual=%b expected=%b", tag, ch,
                 status_words[4*ch +: 4], exp_s);
      end
    end
  endtask

  task automatic check_bit(string tag, int idx, bit exp);
    checks++;
    if (status_words[idx] !== exp) begin
      failures++;
      $display("FAIL %s status bit %0d actual=%b expected=%b", tag, idx,
               status_words[idx], exp);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    #1;
    model_step();
    check_all(tag);
  endtask

  task automatic drive_one(int ch, int v, bit c_hi, bit c_lo);
    sample_valid = '0;
    sample_valid[ch] = 1'b1;
    sample_in[ch*DW +: DW] = v[DW-1:0];
    cancel_words[2*ch] = c_hi;
    cancel_words[2*ch+1] = c_lo;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681357));
    for (int ch = 0; ch < NCH; ch++) begin
      lim_hi[ch] = 100 + ch * 40;
      lim_lo[ch] = -(100 + ch * 30);
      hi_limit_in[ch*DW +: DW] = lim_hi[ch][DW-1:0];
      lo_limit_in[ch*DW +: DW] = lim_lo[ch][DW-1:0];
      m_data[ch] = 0;
      m_ov[ch] = 0; m_un[ch] = 0; m_hi[ch] = 0; m_lo[ch] = 0;
      m_ph[ch] = 0; m_pl[ch] = 0;
    end
    sample_in = {NCH{16'h7fff}};
    sample_valid = '1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    rst = 1'b0;
    sample_valid = '0;

    // Range flags and clamping on channel 0 (limits 100 / -100)
    drive_one(0, 1200, 0, 0);  tick("R2 over clamp");
    check_bit("R9 over at bit0", 0, 1'b1);
    drive_one(0, 1000, 0, 0);  tick("R4 at max");
    drive_one(0, -1001, 0, 0); tick("R3 under clamp");
    check_bit("R9 under at bit1", 1, 1'b1);
    drive_one(0, -1000, 0, 0); tick("R4 at min");
    drive_one(0, 0, 0, 0);     tick("R4 in range");

    // High alarm handshake on channel 3 (high limit 220)
    drive_one(3, 220, 0, 0);   tick("R5 high latches at limit");
    check_bit("R9 high alarm ch3 bit15", 15, 1'b1);
    drive_one(3, 0, 0, 0);     tick("R5 sticky after condition ends");
    drive_one(3, 500, 1, 0);   tick("R7 cancel during persist ignored");
    check_bit("R7 still latched", 15, 1'b1);
    drive_one(3, 219, 1, 0);   tick("R7 clears on first absent sample");
    check_bit("R7 cleared", 15, 1'b0);
    drive_one(3, 600, 1, 0);   tick("R8 appearance under cancel ignored");
    check_bit("R8 not latched", 15, 1'b0);
    drive_one(3, 600, 0, 0);   tick("R8 persisting condition no latch");
    check_bit("R8 still not latched", 15, 1'b0);
    drive_one(3, 0, 0, 0);     tick("R5 condition gone");
    drive_one(3, 600, 0, 0);   tick("R5 relatch on new appearance");

    // Low alarm on channel 9 (low limit -370), cancel bit 19 = word1 bit3
    drive_one(9, -370, 0, 0);  tick("R6 low latches at limit");
    check_bit("R9 low alarm ch9 bit38", 38, 1'b1);
    drive_one(9, -369, 0, 1);  tick("R7 low clears via bit19");
    check_bit("R9 low cleared", 38, 1'b0);

    // No strobe: wild samples must not disturb anything
    sample_valid = '0;
    sample_in = {NCH{16'h8000}};
    cancel_words = '1;
    tick("R10 no strobe");
    tick("R10 no strobe again");

    // Constrained random mix
    for (int it = 0; it < 3000; it++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        int v;
        v = int'($urandom_range(3000)) - 1500;
        sample_in[ch*DW +: DW] = v[DW-1:0];
        sample_valid[ch] = ($urandom_range(3) != 0);
        cancel_words[2*ch]   = ($urandom_range(3) == 0);
        cancel_words[2*ch+1] = ($urandom_range(3) == 0);
      end
      tick("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule